// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves words between I/O devices and memory for up to four channels. Software programs each channel with one write that carries a direction, a start address and a word count. The write also arms the channel. An armed channel whose device raises its request line asks the processor for the bus and waits for the grant. It then runs the whole block as a series of two-clock bus cycles, and the device acknowledge stays asserted for the full service.

Data never enters the controller. In each bus cycle the memory strobe and the I/O strobe of opposite sense fire together, so the word passes straight from source to destination. When the count runs out, the controller gives the bus back, disarms the channel and raises that channel's completion interrupt. The interrupt stays set until the channel is programmed again.

Top module: `dma_flyby`

## Requirements
- R1: After synchronous reset, hold_req, dev_ack, every strobe, tc and irq are all 0.
- R2: An armed channel with dev_req high raises hold_req one clock later. A request from an unarmed channel leaves hold_req at 0.
- R3: While hold_ack has not been sampled high, no dev_ack bit and no strobe is asserted. The first strobe clock is the clock after the one in which hold_ack is sampled high.
- R4: Direction 0 (memory to device) asserts mem_rd with io_wr. Direction 1 (device to memory) asserts io_rd with mem_wr. The strobes of the other pairing stay low.
- R5: Each transfer lasts two clocks, with strobes high in the first and low in the second. mem_addr equals the start address on the first transfer and then increases by one per transfer, wrapping at the address width.
- R6: A programmed count C moves C+1 words. tc is high only in the strobe clock of the last transfer.
- R7: On the clock after the last transfer's second clock, hold_req and dev_ack fall together and the channel's irq bit is set. That bit stays set until the channel is programmed again, and the programming write clears it.
- R8: When several armed channels request at once, the lowest channel number is served first.
- R9: Arbitration takes place only while the bus is not held. A request that arrives during a service waits until that service completes, and the served channel's dev_ack bit does not change mid-service.
- R10: A programming write to the channel currently in service is ignored. Its transfer keeps its original addresses and the channel is not re-armed.
- R11: dev_ack has at most one bit set, the bit of the channel in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_dir | input | 1 | 0 memory to device, 1 device to memory |
| cfg_addr | input | 16 | Start memory address |
| cfg_cnt | input | 8 | Word count minus one |
| dev_req | input | 4 | Per-channel device request |
| dev_ack | output | 4 | Per-channel device acknowledge |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | 16 | Memory address of the current transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal-count pulse on the last transfer |
| irq | output | 4 | Per-channel completion interrupt |

## Verification
The bench holds off the grant for several clocks after hold_req rises. A design that strobes before the grant shows activity in those clocks. It runs a count of zero, where an off-by-one design moves no word or two, and it starts one block just below the top of the address space to expose a missing wrap. Two channels request together to catch an inverted priority. While a service is running, the bench raises a higher-priority request and writes to the channel in service. A design that rearbitrates switches dev_ack mid-block, and one that accepts the write shows new addresses or re-arms the channel afterwards.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XA   = 2'd2,
    ST_XB   = 2'd3
  } dma_st_e;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_vld
);
  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    gnt_idx = '0;
    gnt_vld = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_idx = IDX_W'(i);
        gnt_vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog,
  input  logic              prog_dir,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic              busy,
  input  logic              step,
  input  logic              finish,
  output logic              armed,
  output logic              dir,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              done_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      dir      <= 1'b0;
      addr     <= '0;
      cnt      <= '0;
      done_irq <= 1'b0;
    end else if (prog && !busy) begin
      armed    <= 1'b1;
      dir      <= prog_dir;
      addr     <= prog_addr;
      cnt      <= prog_cnt;
      done_irq <= 1'b0;
    end else begin
      if (step) begin
        addr <= addr + 1'b1;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
      if (finish) begin
        armed    <= 1'b0;
        done_irq <= 1'b1;
      end
    end
  end

  // R10: a write during service leaves the count untouched
  p_prog_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (prog && busy && !step) |=> $stable(cnt));
endmodule

// File: rtl/dma_flyby.sv
module dma_flyby #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic              cfg_dir,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [NCH-1:0]    dev_req,
  output logic [NCH-1:0]    dev_ack,
  output logic              hold_req,
  input  logic              hold_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              tc,
  output logic [NCH-1:0]    irq
);
  import dma_pkg::*;

  dma_st_e           state;
  logic [CH_W-1:0]   cur;
  logic              last_q;
  logic [NCH-1:0]    ch_armed, ch_dir;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [CNT_W-1:0]  ch_cnt  [NCH];
  logic [CH_W-1:0]   gnt_idx;
  logic              gnt_vld;
  logic              go_xfer;
  logic              sel_dir, sel_last;
  logic [ADDR_W-1:0] sel_addr;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .prog     (cfg_we && (cfg_ch == CH_W'(g))),
        .prog_dir (cfg_dir),
        .prog_addr(cfg_addr),
        .prog_cnt (cfg_cnt),
        .busy     ((state != ST_IDLE) && (cur == CH_W'(g))),
        .step     ((state == ST_XA) && (cur == CH_W'(g))),
        .finish   ((state == ST_XB) && last_q && (cur == CH_W'(g))),
        .armed    (ch_armed[g]),
        .dir      (ch_dir[g]),
        .addr     (ch_addr[g]),
        .cnt      (ch_cnt[g]),
        .done_irq (irq[g])
      );
    end
  endgenerate

  dma_prio_arb #(.N(NCH)) i_arb (
    .req    (ch_armed & dev_req),
    .gnt_idx(gnt_idx),
    .gnt_vld(gnt_vld)
  );

  always_comb begin
    sel_dir  = ch_dir[cur];
    sel_addr = ch_addr[cur];
    sel_last = (ch_cnt[cur] == '0);
    go_xfer  = ((state == ST_WAIT) && hold_ack) || ((state == ST_XB) && !last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur      <= '0;
      last_q   <= 1'b0;
      hold_req <= 1'b0;
      dev_ack  <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      io_rd    <= 1'b0;
      io_wr    <= 1'b0;
      tc       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (gnt_vld) begin
          cur      <= gnt_idx;
          hold_req <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: ;
        ST_XA: begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
          io_rd  <= 1'b0;
          io_wr  <= 1'b0;
          tc     <= 1'b0;
          state  <= ST_XB;
        end
        ST_XB: if (last_q) begin
          hold_req <= 1'b0;
          dev_ack  <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (go_xfer) begin
        state    <= ST_XA;
        dev_ack  <= {{(NCH-1){1'b0}}, 1'b1} << cur;
        mem_addr <= sel_addr;
        mem_rd   <= !sel_dir;
        io_wr    <= !sel_dir;
        mem_wr   <= sel_dir;
        io_rd    <= sel_dir;
        tc       <= sel_last;
        last_q   <= sel_last;
      end
    end
  end

  // R3: acknowledge only follows a sampled grant
  p_ack_after_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(|dev_ack) |-> $past(hold_ack));
  // R7: acknowledge never outlives the bus request
  p_ack_under_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (|dev_ack) |-> hold_req);
  // R11
  p_onehot_ack_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_ack));
  // R4: strobe pairs exclusive
  p_dir_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || io_wr) |-> !(mem_wr || io_rd));
  // R5: strobes last exactly one clock
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr));
  // R6: terminal count only alongside a strobe
  p_tc_on_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    tc |-> (mem_rd || mem_wr));
  // R9: served channel fixed for the whole service
  p_no_switch_r9: assert property (@(posedge clk) disable iff (rst)
    ((|dev_ack) && $past(|dev_ack)) |-> $stable(dev_ack));
endmodule

// File: tb/test_dma_flyby.sv
module test_dma_flyby;
  localparam int CLK_P = 10;
  localparam logic [26:0] VEC [4] = '{
    {2'd0, 1'b0, 16'h1000, 8'd0},
    {2'd1, 1'b1, 16'h20FE, 8'd3},
    {2'd2, 1'b0, 16'hFFFE, 8'd2},
    {2'd3, 1'b1, 16'h0040, 8'd5}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [15:0] cfg_addr = '0;
  logic [7:0] cfg_cnt = '0;
  logic [3:0] dev_req = '0;
  logic hold_ack = 1'b0;
  logic [3:0] dev_ack, irq;
  logic hold_req, mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] mem_addr;
  int checks = 0, errors = 0, cycles = 0;

  dma_flyby i_dma_flyby (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_dir(cfg_dir),
    .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .dev_req(dev_req), .dev_ack(dev_ack),
    .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .tc(tc), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic program_ch(input logic [1:0] ch, input logic dir,
                            input logic [15:0] addr, input logic [7:0] cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = ch; cfg_dir = dir; cfg_addr = addr; cfg_cnt = cnt;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // entered right after the negedge where the request became visible
  task automatic serve(input int ch, input logic dir, input logic [15:0] addr,
                       input int cnt);
    logic [3:0] strb;
    @(negedge clk);
    chk(hold_req === 1'b1, "R2 hold request raised", hold_req, 1);
    chk(dev_ack === 4'h0, "R3 no ack before grant", dev_ack, 0);
    repeat (2) begin
      @(negedge clk);
      strb = {mem_rd, mem_wr, io_rd, io_wr};
      chk(strb === 4'h0 && dev_ack === 4'h0, "R3 idle bus while ungranted", strb, 0);
    end
    hold_ack = 1'b1;
    for (int k = 0; k <= cnt; k++) begin
      @(negedge clk);
      strb = {mem_rd, mem_wr, io_rd, io_wr};
      chk(strb === (dir ? 4'b0110 : 4'b1001), "R4 strobe pairing",
          strb, dir ? 4'b0110 : 4'b1001);
      chk(mem_addr === 16'(addr + k), "R5 address step", mem_addr, 16'(addr + k));
      chk(dev_ack === (4'b1 << ch), "R11 one-hot ack", dev_ack, 4'b1 << ch);
      chk(tc === (k == cnt), "R6 terminal count", tc, (k == cnt));
      @(negedge clk);
      strb = {mem_rd, mem_wr, io_rd, io_wr};
      chk(strb === 4'h0 && tc === 1'b0, "R5 strobes released", strb, 0);
      chk(hold_req === 1'b1 && dev_ack === (4'b1 << ch), "R9 bus kept", dev_ack, 4'b1 << ch);
    end
    @(negedge clk);
    chk(hold_req === 1'b0 && dev_ack === 4'h0, "R7 bus released", {hold_req, dev_ack}, 0);
    chk(irq[ch] === 1'b1, "R7 completion irq", irq, 4'b1 << ch);
    hold_ack = 1'b0;
    dev_req[ch] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hold_req === 1'b0 && dev_ack === 4'h0 && tc === 1'b0 && irq === 4'h0 &&
        {mem_rd, mem_wr, io_rd, io_wr} === 4'h0, "R1 reset state",
        {hold_req, dev_ack, irq}, 0);
    rst = 1'b0;

    // R2: unarmed requests are ignored
    dev_req = 4'hF;
    repeat (3) begin
      @(negedge clk);
      chk(hold_req === 1'b0, "R2 unarmed ignored", hold_req, 0);
    end
    dev_req = 4'h0;

    // table of single-channel transfers (R4 R5 R6 R7)
    for (int v = 0; v < 4; v++) begin
      program_ch(VEC[v][26:25], VEC[v][24], VEC[v][23:8], VEC[v][7:0]);
      dev_req[VEC[v][26:25]] = 1'b1;
      serve(int'(VEC[v][26:25]), VEC[v][24], VEC[v][23:8], int'(VEC[v][7:0]));
      @(negedge clk);
    end

    // R7: reprogramming clears the interrupt
    program_ch(2'd2, 1'b0, 16'h0500, 8'd1);
    chk(irq === 4'b1011, "R7 irq cleared by write", irq, 4'b1011);

    // R8: channel 1 beats channel 3
    program_ch(2'd1, 1'b0, 16'h0300, 8'd1);
    program_ch(2'd3, 1'b1, 16'h0700, 8'd2);
    program_ch(2'd0, 1'b0, 16'h0900, 8'd0);
    dev_req = 4'b1010;
    serve(1, 1'b0, 16'h0300, 1);

    // R9 and R10: mid-service request on ch0 and a write to ch3
    fork
      serve(3, 1'b1, 16'h0700, 2);
      begin
        repeat (4) @(negedge clk);
        dev_req[0] = 1'b1;
        cfg_we = 1'b1; cfg_ch = 2'd3; cfg_dir = 1'b0; cfg_addr = 16'hAAAA; cfg_cnt = 8'd9;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    serve(0, 1'b0, 16'h0900, 0);

    // R10: ignored write did not re-arm channel 3
    @(negedge clk);
    dev_req[3] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(hold_req === 1'b0, "R10 write in service ignored", hold_req, 0);
    end
    dev_req = 4'h0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule